// File: doc/BRIEF.md
# Buffered Data Memory

This block is a word-addressed data store placed behind two holding registers: an address register that takes its value from the address bus and a buffer register that exchanges words with the data bus. A four-bit control field steers each access. The surrounding datapath presents a control field and bus values during a phase-1 interval. The block latches them and carries out the access in the phase-0 interval that follows. For a read whose output enable is set, it then places the buffer register on its data-bus output during the next phase-1 interval.

The phase is supplied from outside on `ph1_i`: high for a phase-1 interval and low for a phase-0 interval. The two phases are expected to alternate on successive clocks. When the block is not driving, its bus output is all zeros, so the buses can combine their sources by OR. The storage array is cleared by reset, and an address past the end of the array wraps modulo the array depth.

Top module: `dm_mem_unit`

## Requirements
- R1: After reset the bus output is zero and every array word reads back as zero.
- R2: The control field `ctl_i` is encoded as follows: bit 0 loads the address register from `bus2_i`, bit 1 loads the buffer register from `bus1_i`, bit 2 selects write when 1 and read when 0, and bit 3 enables the buffer register onto `bus1_o`.
- R3: The control field and bus inputs are sampled only at the clock edge that closes a phase-1 interval. Values presented during a phase-0 interval have no effect.
- R4: A read with the address-load bit set latches the address at the edge that closes the next phase-0 interval and loads the buffer register with the array word at that address.
- R5: After a read with bit 3 set, `bus1_o` equals the buffer register during the next phase-1 interval. After a read with bit 3 clear, `bus1_o` stays zero.
- R6: A write with both load bits set latches the address and the data at the edge that closes the next phase-0 interval, and stores that data in the array.
- R7: A write never drives `bus1_o`, whatever the value of bit 3.
- R8: `bus1_o` is zero during every phase-0 interval and whenever no enabled read precedes it.
- R9: The array index is the latched address modulo the array depth.
- R10: With bit 1 set and bit 0 clear, only the buffer register is loaded. A write with bit 1 clear stores the word the buffer register already holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one edge per phase interval |
| rst_n | input | 1 | Active-low synchronous reset |
| ph1_i | input | 1 | High during a phase-1 interval, low during a phase-0 interval |
| ctl_i | input | 4 | Control field (see R2) |
| bus1_i | input | DATA_W | Data bus value into the buffer register |
| bus2_i | input | DATA_W | Address bus value into the address register |
| bus1_o | output | DATA_W | Buffer register onto the data bus, zero when not driving |

## Verification
The bench targets the write that also carries the output-enable bit. A design that ignored the write bit there would put stale data on the shared bus and corrupt the OR. It places a full write command in a phase-0 interval, which a design that samples on every edge would store. It also writes past the array depth and reads back the wrapped word, which catches index truncation written the wrong way. Finally, it loads the buffer register on its own and then writes without a buffer load; a design that took the data bus regardless would store zero instead of the held word.

// File: rtl/dm_pkg.sv
package dm_pkg;
  // Control field layout, bit 3 down to bit 0.
  typedef struct packed {
    logic oe;      // buffer register onto data bus (reads only)
    logic wr;      // 1 = write, 0 = read
    logic buf_ld;  // buffer register load from data bus
    logic adr_ld;  // address register load from address bus
  } dm_ctl_t;

  localparam int CTL_W = $bits(dm_ctl_t);
endpackage

// File: rtl/dm_cmd_stage.sv
module dm_cmd_stage
  import dm_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ph1_i,
  input  dm_ctl_t           ctl_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] addr_i,
  output logic              pend_vld,
  output dm_ctl_t           pend_ctl,
  output logic [DATA_W-1:0] pend_data,
  output logic [DATA_W-1:0] pend_addr,
  output logic              exec_fire
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_vld  <= 1'b0;
      pend_ctl  <= '0;
      pend_data <= '0;
      pend_addr <= '0;
    end else if (ph1_i) begin
      pend_vld  <= 1'b1;
      pend_ctl  <= ctl_i;
      pend_data <= data_i;
      pend_addr <= addr_i;
    end else begin
      pend_vld  <= 1'b0;
    end
  end

  // The held command is carried out in the phase-0 interval after capture.
  assign exec_fire = pend_vld && !ph1_i;
endmodule

// File: rtl/dm_array.sv
module dm_array #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) words[i] <= '0;
    end else if (we) begin
      words[idx] <= wdata;
    end
  end

  assign rdata = words[idx];
endmodule

// File: rtl/dm_bus_drive.sv
module dm_bus_drive #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ph1_i,
  input  logic              arm,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] bus_o
);
  logic drive_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      drive_q <= 1'b0;
    else if (!ph1_i) drive_q <= arm;
    else             drive_q <= 1'b0;
  end

  // Zero when idle so the bus can OR all sources together.
  assign bus_o = (ph1_i && drive_q) ? data : '0;
endmodule

// File: rtl/dm_mem_unit.sv
module dm_mem_unit
  import dm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ph1_i,
  input  logic [3:0]        ctl_i,
  input  logic [DATA_W-1:0] bus1_i,
  input  logic [DATA_W-1:0] bus2_i,
  output logic [DATA_W-1:0] bus1_o
);
  function automatic logic [IDX_W-1:0] wrap_idx(input logic [DATA_W-1:0] a);
    logic [DATA_W-1:0] m;
    m = a % DATA_W'(DEPTH);
    return m[IDX_W-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] pick_buf(
    input logic rd, input logic ld,
    input logic [DATA_W-1:0] arr, input logic [DATA_W-1:0] bus,
    input logic [DATA_W-1:0] held);
    if (rd)      return arr;
    else if (ld) return bus;
    else         return held;
  endfunction

  dm_ctl_t           ctl_in;
  logic              pend_vld;
  dm_ctl_t           pend_ctl;
  logic [DATA_W-1:0] pend_data;
  logic [DATA_W-1:0] pend_addr;
  logic              exec_fire;
  logic              rd_fire;
  logic              wr_fire;
  logic              arm_drive;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] rdata;
  logic [DATA_W-1:0] mbr_nxt;
  logic [DATA_W-1:0] mar_q;
  logic [DATA_W-1:0] mbr_q;

  assign ctl_in = dm_ctl_t'(ctl_i);

  dm_cmd_stage #(.DATA_W(DATA_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .ph1_i(ph1_i),
    .ctl_i(ctl_in), .data_i(bus1_i), .addr_i(bus2_i),
    .pend_vld(pend_vld), .pend_ctl(pend_ctl),
    .pend_data(pend_data), .pend_addr(pend_addr),
    .exec_fire(exec_fire)
  );

  assign rd_fire   = exec_fire && pend_ctl.adr_ld && !pend_ctl.wr;
  assign wr_fire   = exec_fire && pend_ctl.adr_ld &&  pend_ctl.wr;
  assign arm_drive = exec_fire && pend_ctl.oe && !pend_ctl.wr;
  assign idx       = wrap_idx(pend_addr);
  assign mbr_nxt   = pick_buf(rd_fire, pend_ctl.buf_ld, rdata, pend_data, mbr_q);

  dm_array #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_arr (
    .clk(clk), .rst_n(rst_n), .we(wr_fire), .idx(idx),
    .wdata(mbr_nxt), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mar_q <= '0;
      mbr_q <= '0;
    end else if (exec_fire) begin
      if (pend_ctl.adr_ld) mar_q <= pend_addr;
      mbr_q <= mbr_nxt;
    end
  end

  dm_bus_drive #(.DATA_W(DATA_W)) u_drv (
    .clk(clk), .rst_n(rst_n), .ph1_i(ph1_i),
    .arm(arm_drive), .data(mbr_q), .bus_o(bus1_o)
  );
endmodule

// File: rtl/dm_mem_unit_chk.sv
module dm_mem_unit_chk
  import dm_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ph1_i,
  input logic [DATA_W-1:0] bus1_o,
  input logic              exec_fire,
  input logic              rd_fire,
  input logic              wr_fire,
  input dm_ctl_t           pend_ctl,
  input logic [DATA_W-1:0] pend_addr,
  input logic [DATA_W-1:0] mar_q,
  input logic [DATA_W-1:0] mbr_q,
  input logic [DATA_W-1:0] rdata
);
  // R8
  p_phase0_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ph1_i |-> bus1_o == '0);

  // R7
  p_write_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> bus1_o == '0);

  // R5
  p_read_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && pend_ctl.oe) |=> (!ph1_i || bus1_o == mbr_q));

  // R4
  p_read_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> mbr_q == $past(rdata));

  // R6
  p_addr_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_fire && pend_ctl.adr_ld) |=> mar_q == $past(pend_addr));

  // R3
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_fire |=> ($stable(mar_q) && $stable(mbr_q)));
endmodule

bind dm_mem_unit dm_mem_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ph1_i(ph1_i), .bus1_o(bus1_o),
  .exec_fire(exec_fire), .rd_fire(rd_fire), .wr_fire(wr_fire),
  .pend_ctl(pend_ctl), .pend_addr(pend_addr),
  .mar_q(mar_q), .mbr_q(mbr_q), .rdata(rdata)
);

// File: tb/sim_dm_mem_unit.sv
module sim_dm_mem_unit;
  localparam int DW = 16;
  localparam int DEPTH = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ph1_i = 1'b0;
  logic [3:0]    ctl_i = '0;
  logic [DW-1:0] bus1_i = '0;
  logic [DW-1:0] bus2_i = '0;
  logic [DW-1:0] bus1_o;

  int compared = 0;
  int mismatched = 0;

  // Reference model state
  logic [DW-1:0] m_mem [DEPTH];
  logic [DW-1:0] m_buf;
  bit            m_drive;
  bit            p_vld;
  logic [3:0]    p_ctl;
  logic [DW-1:0] p_data, p_addr;
  string         p_tag = "R1";

  always #10 clk = ~clk;  // 50 MHz

  dm_mem_unit #(.DATA_W(DW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .ph1_i(ph1_i), .ctl_i(ctl_i),
    .bus1_i(bus1_i), .bus2_i(bus2_i), .bus1_o(bus1_o)
  );

  task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: bus1_o actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge(input bit ph, input logic [3:0] c,
                            input logic [DW-1:0] b1, input logic [DW-1:0] b2, input string tag);
    logic [DW-1:0] nb;
    int i;
    if (ph) begin
      p_vld = 1; p_ctl = c; p_data = b1; p_addr = b2; p_tag = tag; m_drive = 0;
    end else begin
      m_drive = 0;
      if (p_vld) begin
        i = int'(p_addr) % DEPTH;
        if (p_ctl[0] && !p_ctl[2]) nb = m_mem[i];
        else if (p_ctl[1])         nb = p_data;
        else                       nb = m_buf;
        if (p_ctl[0] && p_ctl[2])  m_mem[i] = nb;
        m_buf = nb;
        m_drive = p_ctl[3] && !p_ctl[2];
      end
      p_vld = 0;
    end
  endtask

  task automatic step(input bit ph, input logic [3:0] c,
                      input logic [DW-1:0] b1, input logic [DW-1:0] b2, input string tag);
    ph1_i = ph; ctl_i = c; bus1_i = b1; bus2_i = b2;
    #1;
    if (ph) check(bus1_o, m_drive ? m_buf : '0, p_tag);
    else    check(bus1_o, '0, "R8");
    @(posedge clk);
    model_edge(ph, c, b1, b2, tag);
    @(negedge clk);
  endtask

  task automatic op(input logic [3:0] c, input logic [DW-1:0] b1,
                    input logic [DW-1:0] b2, input string tag);
    step(1'b1, c, b1, b2, tag);
    step(1'b0, 4'h0, '0, '0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    m_buf = '0; m_drive = 0; p_vld = 0; p_ctl = '0; p_data = '0; p_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(bus1_o, '0, "R1");                // reset state
    op(4'b1001, '0, 16'd5, "R1");           // read never-written word
    // R6 write, then R4/R5 read back with enable
    op(4'b0111, 16'h1234, 16'd10, "R6");
    op(4'b1001, '0, 16'd10, "R4");
    op(4'b0001, '0, 16'd10, "R5");          // read without enable: bus stays zero
    op(4'b0000, '0, '0, "R5");
    // R7 write carrying the enable bit
    op(4'b1111, 16'hA5A5, 16'd11, "R7");
    op(4'b0000, '0, '0, "R7");
    op(4'b1001, '0, 16'd11, "R6");
    // R9 wrap past the depth
    op(4'b0111, 16'h0F0F, 16'(DEPTH + 7), "R9");
    op(4'b1001, '0, 16'd7, "R9");
    op(4'b1001, '0, 16'(3 * DEPTH + 7), "R9");
    // R10 buffer-only load, then write with no buffer load
    op(4'b0010, 16'hBEEF, '0, "R10");
    op(4'b1000, '0, '0, "R10");             // drive held buffer
    op(4'b0101, 16'h0000, 16'd20, "R10");
    op(4'b1001, '0, 16'd20, "R10");
    // R3 command presented in phase 0 only
    step(1'b1, 4'h0, '0, '0, "R3");
    step(1'b0, 4'b0111, 16'h9999, 16'd30, "R3");
    op(4'b1001, '0, 16'd30, "R3");
    op(4'b0000, '0, '0, "R3");
    // R2 mixed control patterns
    for (int k = 0; k < 400; k++) begin
      logic [3:0] c;
      c = 4'($urandom_range(0, 15));
      op(c, 16'($urandom), 16'($urandom_range(0, 4 * DEPTH)), "R2");
    end
    op(4'b0000, '0, '0, "R2");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule